// File: doc/BRIEF.md
# Segment and Page Address Router

This block stands between a requester and the page translation buffer and picks, for every 32-bit virtual address, one of three paths. When translation is switched off, the address comes back unchanged with every permission granted. When translation is on and the access runs in kernel mode, a per-segment mask can mark the segment named by the top four address bits as directly mapped. The physical top nibble then comes from a packed table of sixteen 4-bit bases held in two 32-bit base registers, and the lower 28 bits are copied. Every other access is handed to the page lookup at once, in the same cycle. Execute fetches are steered to the instruction side and loads and stores to the data side.

The routing decision is combinational. The result for each request is registered and returned exactly one cycle later. Four configuration registers are loaded through a small write port. A write changes routing for requests from the following cycle onward.

Top module: `seg_page_router`

## Requirements
- R1: After reset all four configuration registers are zero, so translation is off, and `rsp_valid` is low until the first request has been registered.
- R2: Translation is on exactly when bit 2 or bit 3 of the global register (select 0) is set. While it is off, a request returns `rsp_paddr` equal to the virtual address, `rsp_perm` = 3'b111 and `rsp_miss` = 0, and `pl_valid` stays low.
- R3: The segment number is `req_vaddr[31:28]`. With translation on, a kernel access (`req_user` = 0) is directly mapped exactly when bit [segment] of the segment-mask register (select 1, bits 15:0) is set.
- R4: For a directly mapped access, segments 0 to 7 take their base from the low base register (select 2) and segments 8 to 15 from the high one (select 3). The base is the nibble at bits [4*(seg mod 8)+3 : 4*(seg mod 8)]. `rsp_paddr` = {base, vaddr[27:0]}, `rsp_perm` = 3'b111 and `rsp_miss` = 0.
- R5: Any other access made with translation on raises `pl_valid` in the same cycle with `pl_vaddr` equal to the virtual address. Its result has `rsp_miss` = 1, `rsp_perm` = 3'b000 and `rsp_paddr` = 0.
- R6: The access type is encoded as 0 = read, 1 = write, 2 = execute, 3 = treated as read. `pl_imem` is 1 for execute (instruction side) and 0 otherwise (data side).
- R7: A user-mode access (`req_user` = 1) is never directly mapped, whatever the mask holds.
- R8: `rsp_valid` is high in the cycle after a cycle with `req_valid` high and low otherwise. Back-to-back requests each get their own result.
- R9: A register write in the same cycle as a request does not affect that request. It applies from the next cycle.
- R10: Bits of the global register other than 2 and 3 have no effect on routing.
- R11: `rsp_perm` bit order is [0] = read, [1] = write, [2] = execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 global, 1 segment mask, 2 low base, 3 high base |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access type (R6 encoding) |
| req_user | input | 1 | 1 = user-mode access |
| pl_valid | output | 1 | Page lookup request (combinational) |
| pl_imem | output | 1 | 1 = instruction side, 0 = data side |
| pl_vaddr | output | 32 | Address handed to page lookup |
| rsp_valid | output | 1 | Registered result valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permissions {exec, write, read} |
| rsp_miss | output | 1 | 1 = result must come from the page lookup |

## Verification
The assertions assume that `req_acc`, `req_user` and `req_vaddr` carry known values whenever `req_valid` is high, and that `cfg_we` and `cfg_sel` are never unknown after reset. The stimulus drives every input at the falling edge with defined values, including idle cycles, and holds the write strobe low except in the cycles that load a register. Requests are also issued during register writes, so the one-cycle-late effect of a write is exercised without leaving those assumptions.

// File: rtl/ar_pkg.sv
package ar_pkg;

   // register selects on the configuration write port
   localparam logic [1:0] SEL_GLOBAL = 2'd0;
   localparam logic [1:0] SEL_MASK   = 2'd1;
   localparam logic [1:0] SEL_KB_LO  = 2'd2;
   localparam logic [1:0] SEL_KB_HI  = 2'd3;

   // access type codes
   localparam logic [1:0] ACC_READ  = 2'd0;
   localparam logic [1:0] ACC_WRITE = 2'd1;
   localparam logic [1:0] ACC_EXEC  = 2'd2;

   localparam int PERM_W = 3;
   localparam logic [PERM_W-1:0] PERM_ALL  = 3'b111;
   localparam logic [PERM_W-1:0] PERM_NONE = 3'b000;

   typedef enum logic [1:0] {
      ROUTE_FLAT = 2'd0,
      ROUTE_SEG  = 2'd1,
      ROUTE_PAGE = 2'd2
   } route_e;

endpackage

// File: rtl/ar_cfg_regs.sv
module ar_cfg_regs
   import ar_pkg::*;
#(
   parameter int                DATA_W  = 32,
   parameter int                NSEG    = 16,
   parameter logic [DATA_W-1:0] EN_MASK = 'hC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              mmu_on,
   output logic [NSEG-1:0]   seg_mask,
   output logic [DATA_W-1:0] kbase_lo,
   output logic [DATA_W-1:0] kbase_hi
);

   if (NSEG > DATA_W) begin : g_bad_mask
      $error("segment mask does not fit the register width");
   end
   if (EN_MASK == '0) begin : g_bad_en
      $error("enable mask selects no bit");
   end

   logic [DATA_W-1:0] gcfg_q;
   logic [NSEG-1:0]   mask_q;
   logic [DATA_W-1:0] klo_q;
   logic [DATA_W-1:0] khi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcfg_q <= '0;
         mask_q <= '0;
         klo_q  <= '0;
         khi_q  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_GLOBAL: gcfg_q <= wr_data & EN_MASK;
            SEL_MASK:   mask_q <= wr_data[NSEG-1:0];
            SEL_KB_LO:  klo_q  <= wr_data;
            default:    khi_q  <= wr_data;
         endcase
      end
   end

   assign mmu_on   = |gcfg_q;
   assign seg_mask = mask_q;
   assign kbase_lo = klo_q;
   assign kbase_hi = khi_q;

   // R9: a base register only changes after its own write
   a_r9_lo_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_KB_LO) |=> $stable(kbase_lo));
   a_r9_hi_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_KB_HI) |=> $stable(kbase_hi));
   a_r9_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_MASK) |=> $stable(seg_mask));

endmodule

// File: rtl/ar_seg_decode.sv
module ar_seg_decode #(
   parameter int ADDR_W = 32,
   parameter int SEG_W  = 4,
   localparam int NSEG  = 2 ** SEG_W,
   localparam int HALF  = NSEG / 2,
   localparam int KB_W  = HALF * SEG_W
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              user,
   input  logic              mmu_on,
   input  logic [NSEG-1:0]   seg_mask,
   input  logic [KB_W-1:0]   kbase_lo,
   input  logic [KB_W-1:0]   kbase_hi,
   output logic              direct,
   output logic [ADDR_W-1:0] seg_paddr
);

   if (SEG_W < 2 || SEG_W >= ADDR_W) begin : g_bad_seg
      $error("segment field width out of range");
   end

   logic [SEG_W-1:0] seg;
   logic [SEG_W-2:0] slot;
   logic             upper;
   logic [SEG_W-1:0] nib_lo [HALF];
   logic [SEG_W-1:0] nib_hi [HALF];
   logic [SEG_W-1:0] base;

   assign seg   = vaddr[ADDR_W-1 -: SEG_W];
   assign slot  = seg[SEG_W-2:0];
   assign upper = seg[SEG_W-1];

   for (genvar g = 0; g < HALF; g++) begin : g_nib
      assign nib_lo[g] = kbase_lo[g*SEG_W +: SEG_W];
      assign nib_hi[g] = kbase_hi[g*SEG_W +: SEG_W];
   end

   assign base      = upper ? nib_hi[slot] : nib_lo[slot];
   assign direct    = mmu_on && !user && seg_mask[seg];
   assign seg_paddr = {base, vaddr[ADDR_W-SEG_W-1:0]};

endmodule

// File: rtl/ar_route.sv
module ar_route
   import ar_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [1:0]        acc,
   input  logic              mmu_on,
   input  logic              direct,
   input  logic [ADDR_W-1:0] seg_paddr,
   output logic              pl_valid,
   output logic              pl_imem,
   output logic [ADDR_W-1:0] nxt_paddr,
   output logic [PERM_W-1:0] nxt_perm,
   output logic              nxt_miss
);

   route_e route;

   always_comb begin
      if (!mmu_on)     route = ROUTE_FLAT;
      else if (direct) route = ROUTE_SEG;
      else             route = ROUTE_PAGE;
   end

   always_comb begin
      nxt_paddr = '0;
      nxt_perm  = PERM_NONE;
      nxt_miss  = 1'b1;
      case (route)
         ROUTE_FLAT: begin
            nxt_paddr = vaddr;
            nxt_perm  = PERM_ALL;
            nxt_miss  = 1'b0;
         end
         ROUTE_SEG: begin
            nxt_paddr = seg_paddr;
            nxt_perm  = PERM_ALL;
            nxt_miss  = 1'b0;
         end
         default: ;
      endcase
   end

   assign pl_valid = req_valid && (route == ROUTE_PAGE);
   assign pl_imem  = (acc == ACC_EXEC);

endmodule

// File: rtl/ar_result.sv
module ar_result
   import ar_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_paddr,
   input  logic [PERM_W-1:0] in_perm,
   input  logic              in_miss,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_paddr,
   output logic [PERM_W-1:0] out_perm,
   output logic              out_miss
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_paddr <= '0;
         out_perm  <= PERM_NONE;
         out_miss  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_paddr <= in_paddr;
            out_perm  <= in_perm;
            out_miss  <= in_miss;
         end
      end
   end

   // R8: one result per request, one cycle later
   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

endmodule

// File: rtl/seg_page_router.sv
module seg_page_router
   import ar_pkg::*;
#(
   parameter int          ADDR_W  = 32,
   parameter int          SEG_W   = 4,
   parameter int          DATA_W  = 32,
   parameter logic [31:0] EN_BITS = 32'h0000_000C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [1:0]        req_acc,
   input  logic              req_user,
   output logic              pl_valid,
   output logic              pl_imem,
   output logic [ADDR_W-1:0] pl_vaddr,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [2:0]        rsp_perm,
   output logic              rsp_miss
);

   localparam int NSEG = 2 ** SEG_W;
   localparam int KB_W = (NSEG / 2) * SEG_W;
   localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(EN_BITS);

   if (KB_W != DATA_W) begin : g_bad_kb
      $error("packed base table must fill one register");
   end

   logic              mmu_on;
   logic [NSEG-1:0]   seg_mask;
   logic [KB_W-1:0]   kbase_lo;
   logic [KB_W-1:0]   kbase_hi;
   logic              direct;
   logic [ADDR_W-1:0] seg_paddr;
   logic [ADDR_W-1:0] nxt_paddr;
   logic [PERM_W-1:0] nxt_perm;
   logic              nxt_miss;

   ar_cfg_regs #(.DATA_W(DATA_W), .NSEG(NSEG), .EN_MASK(EN_MASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
      .wr_data(cfg_wdata), .mmu_on(mmu_on), .seg_mask(seg_mask),
      .kbase_lo(kbase_lo), .kbase_hi(kbase_hi));

   ar_seg_decode #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_dec (
      .vaddr(req_vaddr), .user(req_user), .mmu_on(mmu_on),
      .seg_mask(seg_mask), .kbase_lo(kbase_lo), .kbase_hi(kbase_hi),
      .direct(direct), .seg_paddr(seg_paddr));

   ar_route #(.ADDR_W(ADDR_W)) u_route (
      .req_valid(req_valid), .vaddr(req_vaddr), .acc(req_acc),
      .mmu_on(mmu_on), .direct(direct), .seg_paddr(seg_paddr),
      .pl_valid(pl_valid), .pl_imem(pl_imem), .nxt_paddr(nxt_paddr),
      .nxt_perm(nxt_perm), .nxt_miss(nxt_miss));

   ar_result #(.ADDR_W(ADDR_W)) u_res (
      .clk(clk), .rst_n(rst_n), .in_valid(req_valid),
      .in_paddr(nxt_paddr), .in_perm(nxt_perm), .in_miss(nxt_miss),
      .out_valid(rsp_valid), .out_paddr(rsp_paddr), .out_perm(rsp_perm),
      .out_miss(rsp_miss));

   assign pl_vaddr = req_vaddr;

   // R2: flat result when translation is off
   a_r2_flat: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mmu_on) |=>
         (rsp_paddr == $past(req_vaddr) && rsp_perm == PERM_ALL && !rsp_miss));
   a_r2_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      !mmu_on |-> !pl_valid);
   // R4: direct segment keeps the low bits and never misses
   a_r4_seg_low: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && direct) |=>
         (rsp_paddr[ADDR_W-SEG_W-1:0] == $past(req_vaddr[ADDR_W-SEG_W-1:0])
          && !rsp_miss && rsp_perm == PERM_ALL));
   // R5: a forwarded request reports a miss with no permission
   a_r5_fwd_miss: assert property (@(posedge clk) disable iff (!rst_n)
      pl_valid |=> (rsp_miss && rsp_perm == PERM_NONE));
   // R6: side selection follows the access type
   a_r6_side: assert property (@(posedge clk) disable iff (!rst_n)
      pl_valid |-> (pl_imem == (req_acc == ACC_EXEC)));
   // R7: user accesses always go to the page lookup when translating
   a_r7_user_paged: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user && mmu_on) |-> pl_valid);

endmodule

// File: tb/sim_seg_page_router.sv
module sim_seg_page_router;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic        pl_valid, pl_imem, rsp_valid, rsp_miss;
   logic [31:0] pl_vaddr, rsp_paddr;
   logic [2:0]  rsp_perm;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // reference register state
   logic [31:0] m_g = '0, m_m = '0, m_lo = '0, m_hi = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_page_router u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .req_user(req_user), .pl_valid(pl_valid),
      .pl_imem(pl_imem), .pl_vaddr(pl_vaddr), .rsp_valid(rsp_valid),
      .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_miss(rsp_miss));

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock of stimulus, entered and left just after a falling edge
   task automatic step(input string tag, input bit v, input logic [31:0] va,
                       input logic [1:0] acc, input bit usr, input bit we,
                       input logic [1:0] sel, input logic [31:0] wd);
      bit on, dir, exp_pl;
      int seg;
      logic [31:0] kb, e_pa;
      logic [3:0] nib;
      logic [2:0] e_perm;
      logic e_miss;
      req_valid = v; req_vaddr = va; req_acc = acc; req_user = usr;
      cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
      #1;
      on  = (m_g[2] == 1'b1) || (m_g[3] == 1'b1);
      seg = int'(va >> 28);
      dir = on && !usr && m_m[seg];
      kb  = (seg >= 8) ? m_hi : m_lo;
      nib = 4'((kb >> ((seg % 8) * 4)) & 32'hF);
      if (!on) begin
         e_pa = va; e_perm = 3'b111; e_miss = 1'b0;
      end else if (dir) begin
         e_pa = {nib, va[27:0]}; e_perm = 3'b111; e_miss = 1'b0;
      end else begin
         e_pa = 32'h0; e_perm = 3'b000; e_miss = 1'b1;
      end
      exp_pl = v && on && !dir;
      chk(tag, "pl_valid", 32'(pl_valid), 32'(exp_pl));
      if (exp_pl) begin
         chk(tag, "pl_vaddr", pl_vaddr, va);
         chk(tag, "pl_imem", 32'(pl_imem), 32'(acc == 2'd2));
      end
      @(posedge clk);
      if (we) begin
         case (sel)
            2'd0: m_g = wd;
            2'd1: m_m = wd;
            2'd2: m_lo = wd;
            default: m_hi = wd;
         endcase
      end
      @(negedge clk);
      chk("R8", "rsp_valid", 32'(rsp_valid), 32'(v));
      if (v) begin
         chk(tag, "rsp_paddr", rsp_paddr, e_pa);
         chk(tag, "rsp_perm", 32'(rsp_perm), 32'(e_perm));
         chk(tag, "rsp_miss", 32'(rsp_miss), 32'(e_miss));
      end
      req_valid = 1'b0; cfg_we = 1'b0;
   endtask

   task automatic wr(input string tag, input logic [1:0] sel, input logic [31:0] wd);
      step(tag, 1'b0, 32'h0, 2'd0, 1'b0, 1'b1, sel, wd);
   endtask

   task automatic rq(input string tag, input logic [31:0] va,
                     input logic [1:0] acc, input bit usr);
      step(tag, 1'b1, va, acc, usr, 1'b0, 2'd0, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
      rq("R1", 32'h1234_5678, 2'd0, 1'b0);
      // R2: translation off, all types and modes
      rq("R2", 32'hF000_0004, 2'd1, 1'b1);
      rq("R2", 32'h8ABC_DEF0, 2'd2, 1'b0);
      rq("R2", 32'h0000_0000, 2'd3, 1'b1);
      // R10: non-enable bits of the global register
      wr("R10", 2'd0, 32'h0000_0003);
      rq("R10", 32'h4000_1000, 2'd2, 1'b0);
      wr("R10", 2'd0, 32'hFFFF_FFF3);
      rq("R10", 32'h5555_AAAA, 2'd0, 1'b1);
      wr("R2", 2'd0, 32'h0000_0004);
      rq("R5", 32'h4000_1000, 2'd0, 1'b0);
      wr("R2", 2'd0, 32'h0000_0008);
      rq("R5", 32'h7654_3210, 2'd1, 1'b0);
      // R4: every segment direct, distinct nibbles
      wr("R4", 2'd1, 32'h0000_FFFF);
      wr("R4", 2'd2, 32'h1357_9BDF);
      wr("R4", 2'd3, 32'h2468_ACE0);
      for (int s = 0; s < 16; s++)
         rq("R4", {4'(s), 28'h0ABC_DEF ^ 28'(s * 32'h0111_1111)}, 2'(s % 3), 1'b0);
      // R11 / R4: permissions of a direct segment
      rq("R11", 32'h9000_0010, 2'd1, 1'b0);
      // R7: user mode with every mask bit set
      for (int s = 0; s < 16; s += 3)
         rq("R7", {4'(s), 28'h000_0100}, 2'd0, 1'b1);
      // R3: only segments 0 and 15 direct
      wr("R3", 2'd1, 32'hFFFF_8001);
      for (int s = 0; s < 16; s++)
         rq("R3", {4'(s), 28'h123_4560}, 2'd0, 1'b0);
      // R6: side selection for each type code
      for (int a = 0; a < 4; a++)
         rq("R6", 32'h3000_0040 + 32'(a), 2'(a), 1'b0);
      // R9: write during a request applies only afterwards
      step("R9", 1'b1, 32'h0000_0800, 2'd0, 1'b0, 1'b1, 2'd1, 32'h0);
      rq("R9", 32'h0000_0800, 2'd0, 1'b0);
      step("R9", 1'b1, 32'hF000_0800, 2'd0, 1'b0, 1'b1, 2'd1, 32'h0000_8000);
      step("R9", 1'b1, 32'hF000_0800, 2'd0, 1'b0, 1'b1, 2'd3, 32'h9000_0000);
      rq("R9", 32'hF000_0800, 2'd2, 1'b0);
      step("R9", 1'b1, 32'hF000_0800, 2'd0, 1'b0, 1'b1, 2'd0, 32'h0);
      rq("R9", 32'hF000_0800, 2'd0, 1'b0);
      // R8: idle gaps and back-to-back
      step("R8", 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 2'd0, 32'h0);
      rq("R8", 32'hABCD_0000, 2'd0, 1'b0);
      rq("R8", 32'h0123_4567, 2'd2, 1'b1);
      step("R8", 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 2'd0, 32'h0);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule